// File: doc/BRIEF.md
# External Interrupt Detection Unit

This block sits between a set of external interrupt request lines and a downstream interrupt controller. Each of the `N_LINES` inputs (32 by default) is brought into the clock domain through a two-flop synchroniser. It is then sensed either as a level or as an edge, with a per-line choice of active sense: high level and rising edge, or low level and falling edge. A detected request is held in a per-line pending flop until software removes it with a write-one-to-clear access. Every line has its own active-high output. That output carries the pending bit whenever the line's block bit is zero. Line n drives input n of a consecutive range on the downstream controller.

Software reaches the block through a simple synchronous register port. A write takes effect on the clock edge at which it is presented. A read returns its data on `bus_rdata` after that edge and holds it until the next read. The register set has six registers: a block (mask) register, a masked status view, a raw status view, a clear register, a sense-polarity register and a trigger-type register. Two further offsets are reserved. They read as zero and ignore writes. A level request that is still being driven cannot be cleared: the pending flop sets again in the same cycle. Software therefore clears a level request only after the source has let go.

Top module: `xirq_unit`

## Requirements
- R1: While `rst_n` is low and just after its release, the block register (offset 0x00) reads all ones, the polarity (0x14) and trigger (0x18) registers read zero, `bus_rdata` is zero, every pending bit is zero and every `irq_out` bit is low.
- R2: With trigger bit n = 0 (level), line n sets its pending bit while its synchronised input equals its polarity bit (1 = high active, 0 = low active). The bit stays set after the input goes inactive, until a clear removes it.
- R3: With trigger bit n = 1 (edge), line n sets its pending bit only on a transition into the active sense (rising when polarity is 1, falling when polarity is 0). A steady active level does not set it again after a clear.
- R4: Writing offset 0x10 clears pending bit n for each data bit n that is 1. Data bits that are 0 change nothing. When a new request (an active level, or a fresh edge) meets a clear in the same cycle, the pending bit stays set.
- R5: A block bit of 1 at offset 0x00 forces `irq_out[n]` low. A block bit of 0 makes `irq_out[n]` equal pending bit n. Outputs are active-high whatever the selected sense.
- R6: A read returns its data on `bus_rdata` one clock after it is presented, and `bus_rdata` holds that value until the next read. Offset 0x08 returns pending AND NOT block. Offset 0x0C returns the pending bits before masking. Offsets 0x00, 0x14 and 0x18 return the last value written to them.
- R7: Offsets 0x04 and 0x1C, the write-only clear offset 0x10, and every address outside 0x00 to 0x1C read as zero. Writes to 0x04, 0x1C and unmapped addresses change no register.
- R8: A change on `irq_in[n]` reaches pending bit n, and through it `irq_out[n]`, on the third rising clock edge after the change: two synchroniser stages, then the latch.
- R9: Writing all ones to 0x10 and then all ones to 0x00 leaves every `irq_out` bit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_in | input | N_LINES | External request lines, asynchronous to `clk` |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | N_LINES | Write data, bit n belongs to line n |
| bus_rdata | output | N_LINES | Read data, valid from the clock after a read |
| irq_out | output | N_LINES | Active-high request to the downstream controller, one per line |

## Verification
Directed patterns raise and drop one line at a time. This separates level from edge sensing, high from low polarity, a clear that lands after the source has gone from one that meets a still-active level or a fresh edge, and the exact three-edge latency from an input change to the output. Sparse random toggling of all lines, mixed with random accesses to every offset and to unmapped addresses, is compared every cycle against a cycle model in the bench. That comparison tells a masking error (raw and masked status disagree) apart from a latching error (a pending bit drops without a clear). It also shows reserved or unmapped writes leaking into real registers.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  // Register byte offsets (software depends on these positions)
  localparam logic [7:0] OFS_BLOCK = 8'h00;
  localparam logic [7:0] OFS_ROUTE = 8'h04;
  localparam logic [7:0] OFS_STAT  = 8'h08;
  localparam logic [7:0] OFS_RAW   = 8'h0C;
  localparam logic [7:0] OFS_ACK   = 8'h10;
  localparam logic [7:0] OFS_POL   = 8'h14;
  localparam logic [7:0] OFS_TRIG  = 8'h18;
  localparam logic [7:0] OFS_SOFT  = 8'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_BLOCK,
    SEL_STAT,
    SEL_RAW,
    SEL_ACK,
    SEL_POL,
    SEL_TRIG
  } rsel_e;

  function automatic rsel_e decode_offset(logic [7:0] ofs);
    rsel_e s;
    case (ofs)
      OFS_BLOCK: s = SEL_BLOCK;
      OFS_STAT:  s = SEL_STAT;
      OFS_RAW:   s = SEL_RAW;
      OFS_ACK:   s = SEL_ACK;
      OFS_POL:   s = SEL_POL;
      OFS_TRIG:  s = SEL_TRIG;
      default:   s = SEL_NONE;   // reserved and unmapped offsets
    endcase
    return s;
  endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stg_d[s] = async_i;
    end else begin : g_next
      always_comb stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/xirq_sense.sv
module xirq_sense #(
  parameter int unsigned N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] sync_i,
  input  logic [N_LINES-1:0] pol_i,
  input  logic [N_LINES-1:0] trig_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] pend_o
);

  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] pend_d;

  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    logic act_now;
    logic act_old;
    logic hit;

    always_comb begin
      act_now = pol_i[n] ? sync_i[n] : ~sync_i[n];
      act_old = pol_i[n] ? prev_q[n] : ~prev_q[n];
      hit     = trig_i[n] ? (act_now & ~act_old) : act_now;
      // a new request wins over a simultaneous clear
      pend_d[n] = hit | (pend_q[n] & ~clr_i[n]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= sync_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [N_LINES-1:0] bus_wdata,
  input  logic [N_LINES-1:0] pend_i,
  output logic [N_LINES-1:0] mask_o,
  output logic [N_LINES-1:0] pol_o,
  output logic [N_LINES-1:0] trig_o,
  output logic [N_LINES-1:0] clr_o,
  output logic [N_LINES-1:0] rdata_o
);

  localparam logic [ADDR_W-1:0] LOW_SPAN = ADDR_W'(8'hFF);

  logic               in_map;
  rsel_e              sel;
  logic               wr_go;
  logic               rd_go;
  logic               mask_en, pol_en, trig_en;
  logic [N_LINES-1:0] mask_q, pol_q, trig_q, rdata_q;
  logic [N_LINES-1:0] rd_mux;

  always_comb begin
    in_map  = (bus_addr & ~LOW_SPAN) == '0;
    sel     = in_map ? decode_offset(bus_addr[7:0]) : SEL_NONE;
    wr_go   = bus_en & bus_we;
    rd_go   = bus_en & ~bus_we;
    mask_en = wr_go && (sel == SEL_BLOCK);
    pol_en  = wr_go && (sel == SEL_POL);
    trig_en = wr_go && (sel == SEL_TRIG);
    clr_o   = (wr_go && (sel == SEL_ACK)) ? bus_wdata : '0;
    case (sel)
      SEL_BLOCK: rd_mux = mask_q;
      SEL_STAT:  rd_mux = pend_i & ~mask_q;
      SEL_RAW:   rd_mux = pend_i;
      SEL_POL:   rd_mux = pol_q;
      SEL_TRIG:  rd_mux = trig_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      pol_q   <= '0;
      trig_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (mask_en) mask_q  <= bus_wdata;
      if (pol_en)  pol_q   <= bus_wdata;
      if (trig_en) trig_q  <= bus_wdata;
      if (rd_go)   rdata_q <= rd_mux;
    end
  end

  assign mask_o  = mask_q;
  assign pol_o   = pol_q;
  assign trig_o  = trig_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/xirq_unit.sv
module xirq_unit #(
  parameter int unsigned N_LINES   = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [N_LINES-1:0] bus_wdata,
  output logic [N_LINES-1:0] bus_rdata,
  output logic [N_LINES-1:0] irq_out
);

  logic [N_LINES-1:0] sync_vec;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] pol_q;
  logic [N_LINES-1:0] trig_q;
  logic [N_LINES-1:0] clr_vec;

  xirq_sync #(.WIDTH(N_LINES), .STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (irq_in),
    .sync_o  (sync_vec)
  );

  xirq_sense #(.N_LINES(N_LINES)) u_sense (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (sync_vec),
    .pol_i  (pol_q),
    .trig_i (trig_q),
    .clr_i  (clr_vec),
    .pend_o (pend_q)
  );

  xirq_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend_i    (pend_q),
    .mask_o    (mask_q),
    .pol_o     (pol_q),
    .trig_o    (trig_q),
    .clr_o     (clr_vec),
    .rdata_o   (bus_rdata)
  );

  assign irq_out = pend_q & ~mask_q;

endmodule

// File: rtl/xirq_unit_chk.sv
module xirq_unit_chk
  import xirq_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_en,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [N_LINES-1:0] bus_wdata,
  input logic [N_LINES-1:0] bus_rdata,
  input logic [N_LINES-1:0] irq_out,
  input logic [N_LINES-1:0] pend_q,
  input logic [N_LINES-1:0] clr_vec
);

  logic wr_ack, wr_blk, rd_stat, rd_raw, rd_zero;

  always_comb begin
    wr_ack  = bus_en &&  bus_we && (bus_addr == ADDR_W'(OFS_ACK));
    wr_blk  = bus_en &&  bus_we && (bus_addr == ADDR_W'(OFS_BLOCK));
    rd_stat = bus_en && !bus_we && (bus_addr == ADDR_W'(OFS_STAT));
    rd_raw  = bus_en && !bus_we && (bus_addr == ADDR_W'(OFS_RAW));
    rd_zero = bus_en && !bus_we && ((bus_addr == ADDR_W'(OFS_ROUTE)) ||
                                    (bus_addr == ADDR_W'(OFS_SOFT))  ||
                                    (bus_addr == ADDR_W'(OFS_ACK)));
  end

  // R1: outputs stay low while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (irq_out == '0);
    end
  end

  // R2: without a clear, no pending bit ever falls
  a_r2_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R4: zero bits of a clear write never drop a pending bit
  a_r4_zero_bits_keep: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> ((~pend_q & $past(pend_q) & ~$past(bus_wdata)) == '0));

  // R5: lines blocked by a mask write are low on the next cycle
  a_r5_blocked_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blk |=> ((irq_out & $past(bus_wdata)) == '0));

  // R6: masked status read equals the outputs at the time of the read
  a_r6_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (bus_rdata == $past(irq_out)));

  // R6: raw status read equals the pending bits at the time of the read
  a_r6_raw_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_raw |=> (bus_rdata == $past(pend_q)));

  // R7: reserved and clear offsets read zero
  a_r7_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero |=> (bus_rdata == '0));

endmodule

bind xirq_unit xirq_unit_chk #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .pend_q    (pend_q),
  .clr_vec   (clr_vec)
);

// File: tb/test_xirq_unit.sv
`timescale 1ns/1ps
module test_xirq_unit;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          bus_en = 1'b0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string cur_tag = "R1";

  // cycle model state
  logic [N-1:0] m_s1, m_s2, m_s3, m_pend, m_mask, m_pol, m_trig, m_rdata;

  always #2 clk = ~clk;

  xirq_unit i_xirq_unit (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_read(logic [7:0] a);
    case (a)
      8'h00:   return m_mask;
      8'h08:   return m_pend & ~m_mask;
      8'h0C:   return m_pend;
      8'h14:   return m_pol;
      8'h18:   return m_trig;
      default: return '0;
    endcase
  endfunction

  // one clock: model next state from pre-edge values, then compare
  task automatic step();
    logic [N-1:0] act, actp, setv, clr, pend_n, rd_n;
    bit is_rd, is_wr;
    logic [7:0] a;
    logic [N-1:0] d;
    act   = (m_pol & m_s2) | (~m_pol & ~m_s2);
    actp  = (m_pol & m_s3) | (~m_pol & ~m_s3);
    setv  = (m_trig & act & ~actp) | (~m_trig & act);
    is_wr = bus_en && bus_we;
    is_rd = bus_en && !bus_we;
    a = bus_addr; d = bus_wdata;
    clr   = (is_wr && a == 8'h10) ? d : '0;
    pend_n = setv | (m_pend & ~clr);
    rd_n  = is_rd ? exp_read(a) : m_rdata;
    @(posedge clk);
    @(negedge clk);
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq_in;
    m_pend = pend_n; m_rdata = rd_n;
    if (is_wr && a == 8'h00) m_mask = d;
    if (is_wr && a == 8'h14) m_pol  = d;
    if (is_wr && a == 8'h18) m_trig = d;
    check({cur_tag, " irq_out"}, irq_out, m_pend & ~m_mask);
    if (is_rd) check({cur_tag, " rdata"}, bus_rdata, m_rdata);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [N-1:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
  endtask

  task automatic rd(logic [7:0] a);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_s1 = '0; m_s2 = '0; m_s3 = '0; m_pend = '0;
    m_mask = '1; m_pol = '0; m_trig = '0; m_rdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1 irq_out in reset", irq_out, '0);
    check("R1 rdata in reset", bus_rdata, '0);
    rst_n = 1'b1;
    cur_tag = "R1";
    rd(8'h00); check("R1 block reg", bus_rdata, '1);
    rd(8'h14); check("R1 polarity reg", bus_rdata, '0);
    rd(8'h18); check("R1 trigger reg", bus_rdata, '0);

    // prepare: high-active level on all lines, clear, unmask
    cur_tag = "R2";
    wr(8'h14, '1);
    idle(3);
    wr(8'h10, '1);
    wr(8'h00, '0);
    check("R2 idle outputs", irq_out, '0);

    // R8: exact latency on line 5
    cur_tag = "R8";
    irq_in[5] = 1'b1;
    step(); check("R8 edge1", {31'b0, irq_out[5]}, 32'd0);
    step(); check("R8 edge2", {31'b0, irq_out[5]}, 32'd0);
    step(); check("R8 edge3", {31'b0, irq_out[5]}, 32'd1);

    // R2: latched after input drops
    cur_tag = "R2";
    irq_in[5] = 1'b0;
    idle(4);
    check("R2 level held", {31'b0, irq_out[5]}, 32'd1);
    wr(8'h10, 32'h0000_0020);
    check("R2 cleared", {31'b0, irq_out[5]}, 32'd0);

    // R4: clear while level active is ignored; zero bits do nothing
    cur_tag = "R4";
    irq_in[5] = 1'b1;
    idle(4);
    wr(8'h10, 32'hFFFF_FFDF);
    check("R4 zero bit keeps", {31'b0, irq_out[5]}, 32'd1);
    wr(8'h10, 32'h0000_0020);
    check("R4 clear under active level", {31'b0, irq_out[5]}, 32'd1);
    irq_in[5] = 1'b0;
    idle(3);
    wr(8'h10, 32'h0000_0020);
    check("R4 clear after release", {31'b0, irq_out[5]}, 32'd0);

    // R2: active-low level on line 6 (input stays low)
    cur_tag = "R2";
    wr(8'h14, 32'hFFFF_FFBF);
    idle(2);
    check("R2 active-low sets", {31'b0, irq_out[6]}, 32'd1);
    irq_in[6] = 1'b1;
    idle(3);
    wr(8'h10, 32'h0000_0040);
    check("R2 active-low cleared", {31'b0, irq_out[6]}, 32'd0);

    // R3: edge sense on line 7
    cur_tag = "R3";
    wr(8'h14, '1);
    wr(8'h18, '1);
    idle(3);
    wr(8'h10, '1);
    irq_in[7] = 1'b1;
    idle(3);
    check("R3 rising edge sets", {31'b0, irq_out[7]}, 32'd1);
    wr(8'h10, 32'h0000_0080);
    idle(4);
    check("R3 steady level no retrigger", {31'b0, irq_out[7]}, 32'd0);
    wr(8'h14, 32'hFFFF_FF7F);
    idle(3);
    wr(8'h10, '1);
    irq_in[7] = 1'b0;
    idle(3);
    check("R3 falling edge sets", {31'b0, irq_out[7]}, 32'd1);
    wr(8'h10, 32'h0000_0080);
    wr(8'h14, '1);
    idle(3);
    wr(8'h10, '1);

    // R4: edge and clear in the same cycle, request wins
    cur_tag = "R4";
    irq_in[8] = 1'b1;
    idle(2);
    wr(8'h10, 32'h0000_0100);
    check("R4 edge beats clear", {31'b0, irq_out[8]}, 32'd1);

    // R5 and R6: masking and status views
    cur_tag = "R5";
    wr(8'h00, 32'h0000_0100);
    check("R5 blocked line low", {31'b0, irq_out[8]}, 32'd0);
    cur_tag = "R6";
    rd(8'h08); check("R6 masked status", bus_rdata & 32'h100, 32'h0);
    rd(8'h0C); check("R6 raw status", bus_rdata & 32'h100, 32'h100);
    idle(2);
    check("R6 rdata holds", bus_rdata & 32'h100, 32'h100);
    cur_tag = "R5";
    wr(8'h00, '0);
    check("R5 unblocked line high", {31'b0, irq_out[8]}, 32'd1);

    // R7: reserved, clear and unmapped offsets
    cur_tag = "R7";
    wr(8'h04, '1); wr(8'h1C, '1); wr(8'h40, '1); wr(8'hFC, '1);
    rd(8'h04); check("R7 route reads zero", bus_rdata, '0);
    rd(8'h1C); check("R7 soft reads zero", bus_rdata, '0);
    rd(8'h10); check("R7 clear reads zero", bus_rdata, '0);
    rd(8'h80); check("R7 unmapped reads zero", bus_rdata, '0);
    rd(8'h00); check("R7 block untouched", bus_rdata, '0);
    rd(8'h14); check("R7 polarity untouched", bus_rdata, '1);

    // random traffic against the model
    cur_tag = "R6 random";
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      irq_in = irq_in ^ ($urandom & $urandom & $urandom);
      r = $urandom;
      if (r[0]) begin
        bus_en = 1'b1;
        bus_we = r[1];
        bus_addr = (r[7:4] < 4'd13) ? {3'b0, r[10:8], 2'b00} : r[23:16];
        bus_wdata = $urandom;
      end
      step();
    end

    // R9: clear all then block all
    cur_tag = "R9";
    wr(8'h10, '1);
    wr(8'h00, '1);
    check("R9 all outputs inactive", irq_out, '0);
    idle(4);
    check("R9 outputs stay inactive", irq_out, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule